// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Splitter

This block sits between a processor's transfer request and an external bus whose ports may be narrower than the transfer. It may also receive a start address that is not aligned. It takes one request and turns it into a sequence of bus accesses. The request carries an address, a transfer size (byte, word, longword or cache line), the width of the addressed port and a burst-enable flag. For every access the block presents an address and a 2-bit size code, and it pulses a start strobe on the first cycle of that access. It holds both values until the bus acknowledges the access. It then launches the next access, or it signals completion after the final one.

Each access moves the largest piece that meets three limits: it fits the port, it does not exceed the bytes still owed, and it is naturally aligned at its address. Misaligned requests therefore break into a mix of byte and word accesses. The size code shown on each access depends on the case. For an aligned transfer wider than the port, a bursting sequence shows the whole transfer size on every beat. A burst-inhibited sequence shows the whole transfer size only on the first access and the port size on the later ones. A misaligned transfer shows each piece's own size. Line transfers always run as an aligned sequence.

The controller is a four-state machine. IDLE waits for a request. LAUNCH is the first cycle of an access and drives the start strobe. HOLD keeps an unacknowledged access on the bus. FINISH raises the completion pulse for one cycle. The transitions are: IDLE to LAUNCH on an accepted request; LAUNCH to HOLD when no acknowledge arrives; LAUNCH or HOLD to LAUNCH on the acknowledge of a non-final access; LAUNCH or HOLD to FINISH on the acknowledge of the final access; FINISH to IDLE unconditionally.

Top module: `dbs_splitter`

## Requirements
- R1: Size codes are 2'b00 longword (4 bytes), 2'b01 byte, 2'b10 word (2 bytes) and 2'b11 line (LINE_BYTES, default 16). The port code uses the same values for width: 2'b01 is an 8-bit port, 2'b10 a 16-bit port, and 2'b00 or 2'b11 a 32-bit port.
- R2: `req_ready` is high only in IDLE. A request is accepted only when `req_valid` and `req_ready` are both high. A request raised while a transfer is in progress is ignored and never launched.
- R3: The first access starts in the cycle after acceptance, with `acc_start` high and `acc_addr` equal to the request address.
- R4: `acc_start` lasts exactly one cycle per access. `acc_addr` and `acc_size` stay constant until that access is acknowledged.
- R5: After an acknowledge of a non-final access, the next access starts in the following cycle. Its address is the previous address plus the bytes just moved.
- R6: Each access moves 4, 2 or 1 bytes: the largest amount that fits the port, does not exceed the remaining bytes, and is aligned at the access address. A longword at offset 1 on a 32-bit port becomes byte@1, word@2, byte@4.
- R7: An aligned transfer no larger than the port is a single access carrying its own size code.
- R8: An aligned transfer larger than the port with bursting enabled shows the request's size code on every access.
- R9: An aligned transfer larger than the port with bursting inhibited shows the request's size code on the first access and the port's size code on every later access. For example, a longword to an 8-bit port gives 00, 01, 01, 01.
- R10: A misaligned transfer shows each access's own piece size code (01 or 10).
- R11: `xfer_done` pulses for one cycle, in the cycle after the final acknowledge. An acknowledge outside an access is ignored. `req_ready` returns in the next cycle.
- R12: For line requests the low log2(LINE_BYTES) address bits are forced to zero, so the sequence starts on a line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Splitter idle, request will be taken |
| req_addr | input | ADDR_W | Transfer start address |
| req_size | input | 2 | Transfer size code |
| req_port | input | 2 | Port width code |
| req_burst | input | 1 | Bursting enabled for this transfer |
| acc_start | output | 1 | First cycle of an access |
| acc_addr | output | ADDR_W | Address of the current access |
| acc_size | output | 2 | Size code of the current access |
| acc_ack | input | 1 | Bus acknowledge of the current access |
| acc_active | output | 1 | An access is on the bus |
| xfer_done | output | 1 | Whole transfer finished |

## Verification
The assertions check, on every cycle, the handshake timing of the sequence. They cover the one-cycle start strobe, address and size stability while an access waits, a launch in the cycle after acceptance, no launch without a preceding acceptance or acknowledge, readiness only when no access is active, completion only after an acknowledge, and line-boundary alignment of a line's first access. Only the bench's scenarios can show the arithmetic of each sequence. That covers the piece sizes chosen for misaligned starts, the address increments, the access counts, and which size code appears on which beat for bursting, burst-inhibited and misaligned transfers across port widths and acknowledge delays.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } sz_code_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LAUNCH,
        S_HOLD,
        S_FINISH
    } seq_state_e;

    // log2 of port width in bytes
    function automatic logic [1:0] port_lg_of(input logic [1:0] port);
        logic [1:0] r;
        case (port)
            2'b01:   r = 2'd0;
            2'b10:   r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

    // size code of a piece of 2**lg bytes
    function automatic logic [1:0] code_of_lg(input logic [1:0] lg);
        logic [1:0] r;
        case (lg)
            2'd0:    r = SZ_BYTE;
            2'd1:    r = SZ_WORD;
            default: r = SZ_LONG;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbs_piece_calc.sv
module dbs_piece_calc #(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       addr_lo,
    input  logic [CNT_W-1:0] remain,
    input  logic [1:0]       port_lg,
    output logic [1:0]       piece_lg,
    output logic [CNT_W-1:0] piece_bytes
);
    localparam int MAX_LG = 2;

    logic [MAX_LG:0] fits;

    genvar g;
    generate
        for (g = 0; g <= MAX_LG; g++) begin : g_lvl
            localparam logic [CNT_W-1:0] STEP = CNT_W'(1) << g;
            localparam logic [1:0]       MASK = 2'((1 << g) - 1);
            assign fits[g] = (2'(g) <= port_lg)
                          && (remain >= STEP)
                          && ((addr_lo & MASK) == 2'b00);
        end
    endgenerate

    always_comb begin
        piece_lg = 2'd0;
        if (fits[2])      piece_lg = 2'd2;
        else if (fits[1]) piece_lg = 2'd1;
        else              piece_lg = 2'd0;
        piece_bytes = CNT_W'(1) << piece_lg;
    end

endmodule

// File: rtl/dbs_code_sel.sv
module dbs_code_sel
    import dbs_pkg::*;
(
    input  logic [1:0] piece_lg,
    input  logic [1:0] req_code,
    input  logic       wide,
    input  logic       burst,
    input  logic       first,
    output logic [1:0] code
);
    always_comb begin
        if (wide && (burst || first))
            code = req_code;
        else
            code = code_of_lg(piece_lg);
    end

endmodule

// File: rtl/dbs_seq_fsm.sv
module dbs_seq_fsm
    import dbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic acc_ack,
    input  logic last_beat,
    output logic req_ready,
    output logic acc_start,
    output logic acc_active,
    output logic xfer_done,
    output logic accept,
    output logic advance
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_LAUNCH;
            S_LAUNCH: begin
                if (acc_ack) state_nx = last_beat ? S_FINISH : S_LAUNCH;
                else         state_nx = S_HOLD;
            end
            S_HOLD:   if (acc_ack) state_nx = last_beat ? S_FINISH : S_LAUNCH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        acc_start  = 1'b0;
        acc_active = 1'b0;
        xfer_done  = 1'b0;
        unique case (state)
            S_IDLE:   req_ready = 1'b1;
            S_LAUNCH: begin
                acc_start  = 1'b1;
                acc_active = 1'b1;
            end
            S_HOLD:   acc_active = 1'b1;
            S_FINISH: xfer_done = 1'b1;
            default:  req_ready = 1'b0;
        endcase
        accept  = req_ready && req_valid;
        advance = acc_active && acc_ack;
    end

endmodule

// File: rtl/dbs_splitter.sv
module dbs_splitter
    import dbs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_port,
    input  logic              req_burst,
    output logic              acc_start,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        acc_size,
    input  logic              acc_ack,
    output logic              acc_active,
    output logic              xfer_done
);
    localparam int LINE_LG = $clog2(LINE_BYTES);
    localparam int CNT_W   = LINE_LG + 1;
    localparam int LG_W    = 3;

    // request decode
    logic [LG_W-1:0]   size_lg;
    logic [CNT_W-1:0]  total;
    logic [ADDR_W-1:0] start_addr;
    logic              aligned;
    logic              wide_in;

    always_comb begin
        case (req_size)
            SZ_BYTE: size_lg = LG_W'(0);
            SZ_WORD: size_lg = LG_W'(1);
            SZ_LONG: size_lg = LG_W'(2);
            default: size_lg = LG_W'(LINE_LG);
        endcase
        total = CNT_W'(1) << size_lg;
        if (req_size == SZ_LINE)
            start_addr = {req_addr[ADDR_W-1:LINE_LG], {LINE_LG{1'b0}}};
        else
            start_addr = req_addr;
        aligned = (start_addr[LINE_LG-1:0]
                   & (total[LINE_LG-1:0] - {{(LINE_LG-1){1'b0}}, 1'b1}))
                  == {LINE_LG{1'b0}};
        wide_in = aligned && (size_lg > LG_W'(port_lg_of(req_port)));
    end

    // held transfer state
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic [1:0]        code_q;
    logic [1:0]        port_lg_q;
    logic              burst_q;
    logic              wide_q;
    logic              first_q;

    logic [1:0]        piece_lg;
    logic [CNT_W-1:0]  piece_bytes;
    logic              last_beat;
    logic              accept;
    logic              advance;

    assign last_beat = (remain == piece_bytes);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remain    <= '0;
            code_q    <= 2'b00;
            port_lg_q <= 2'd0;
            burst_q   <= 1'b0;
            wide_q    <= 1'b0;
            first_q   <= 1'b0;
        end else if (accept) begin
            cur_addr  <= start_addr;
            remain    <= total;
            code_q    <= req_size;
            port_lg_q <= port_lg_of(req_port);
            burst_q   <= req_burst;
            wide_q    <= wide_in;
            first_q   <= 1'b1;
        end else if (advance) begin
            cur_addr  <= cur_addr + ADDR_W'(piece_bytes);
            remain    <= remain - piece_bytes;
            first_q   <= 1'b0;
        end
    end

    dbs_piece_calc #(.CNT_W(CNT_W)) u_piece (
        .addr_lo     (cur_addr[1:0]),
        .remain      (remain),
        .port_lg     (port_lg_q),
        .piece_lg    (piece_lg),
        .piece_bytes (piece_bytes)
    );

    dbs_code_sel u_code (
        .piece_lg (piece_lg),
        .req_code (code_q),
        .wide     (wide_q),
        .burst    (burst_q),
        .first    (first_q),
        .code     (acc_size)
    );

    dbs_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .acc_ack    (acc_ack),
        .last_beat  (last_beat),
        .req_ready  (req_ready),
        .acc_start  (acc_start),
        .acc_active (acc_active),
        .xfer_done  (xfer_done),
        .accept     (accept),
        .advance    (advance)
    );

    assign acc_addr = cur_addr;

endmodule

// File: rtl/dbs_splitter_chk.sv
module dbs_splitter_chk #(
    parameter int ADDR_W  = 32,
    parameter int LINE_LG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              acc_start,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic              acc_ack,
    input logic              acc_active,
    input logic              xfer_done
);
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start && !acc_ack |=> !acc_start);

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_active && !acc_start |-> $stable(acc_addr) && $stable(acc_size));

    // R3
    launch_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> acc_start);

    // R5
    launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |-> $past(req_valid && req_ready) || $past(acc_ack && acc_active));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !acc_active && !xfer_done);

    // R11
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(acc_ack) && $past(acc_active));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done && req_ready);

    // R12
    line_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start && $past(req_valid && req_ready) && acc_size == 2'b11
        |-> acc_addr[LINE_LG-1:0] == '0);

endmodule

bind dbs_splitter dbs_splitter_chk #(
    .ADDR_W  (ADDR_W),
    .LINE_LG (LINE_LG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .acc_start  (acc_start),
    .acc_addr   (acc_addr),
    .acc_size   (acc_size),
    .acc_ack    (acc_ack),
    .acc_active (acc_active),
    .xfer_done  (xfer_done)
);

// File: tb/dbs_splitter_test.sv
module dbs_splitter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_port = '0;
    logic        req_burst = 1'b0;
    logic        acc_start;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic        acc_ack = 1'b0;
    logic        acc_active;
    logic        xfer_done;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dbs_splitter #(.ADDR_W(32), .LINE_BYTES(16)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_port(req_port),
        .req_burst(req_burst), .acc_start(acc_start), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_ack(acc_ack), .acc_active(acc_active),
        .xfer_done(xfer_done)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic [1:0]  port;
        logic        burst;
        logic [4:0]  n;
        logic [1:0]  wt;
        logic [2:0]  kind;   // 0 R7, 1 R8, 2 R9, 3 R10
        logic [31:0] codes;  // access i code at [2i+1:2i]
        logic [31:0] lgs;    // access i log2 bytes at [2i+1:2i]
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h100, 2'b00, 2'b00, 1'b0, 5'd1,  2'd0, 3'd0, 32'h0,        32'h2},
        '{32'h101, 2'b00, 2'b00, 1'b0, 5'd3,  2'd1, 3'd3, 32'h19,       32'h4},
        '{32'h200, 2'b00, 2'b01, 1'b0, 5'd4,  2'd2, 3'd2, 32'h54,       32'h0},
        '{32'h200, 2'b00, 2'b01, 1'b1, 5'd4,  2'd0, 3'd1, 32'h0,        32'h0},
        '{32'h300, 2'b00, 2'b10, 1'b0, 5'd2,  2'd1, 3'd2, 32'h8,        32'h5},
        '{32'h40C, 2'b11, 2'b00, 1'b1, 5'd4,  2'd2, 3'd1, 32'hFF,       32'hAA},
        '{32'h500, 2'b11, 2'b11, 1'b0, 5'd4,  2'd0, 3'd2, 32'h3,        32'hAA},
        '{32'h603, 2'b10, 2'b00, 1'b0, 5'd2,  2'd1, 3'd3, 32'h5,        32'h0},
        '{32'h705, 2'b01, 2'b01, 1'b0, 5'd1,  2'd2, 3'd0, 32'h1,        32'h0},
        '{32'h802, 2'b10, 2'b00, 1'b1, 5'd1,  2'd0, 3'd0, 32'h2,        32'h1},
        '{32'h900, 2'b11, 2'b10, 1'b0, 5'd8,  2'd1, 3'd2, 32'hAAAB,     32'h5555},
        '{32'hA03, 2'b00, 2'b10, 1'b0, 5'd3,  2'd2, 3'd3, 32'h19,       32'h4},
        '{32'hB00, 2'b11, 2'b01, 1'b1, 5'd16, 2'd0, 3'd1, 32'hFFFFFFFF, 32'h0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [2:0] k);
        case (k)
            3'd0:    return "R1/R7";
            3'd1:    return "R8";
            3'd2:    return "R9";
            default: return "R6/R10";
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input bit intrude);
        logic [31:0] ea;
        @(negedge clk);
        chk("R2", "ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = v.addr; req_size = v.size;
        req_port = v.port; req_burst = v.burst;
        @(negedge clk);
        req_valid = 1'b0;
        ea = (v.size == 2'b11) ? {v.addr[31:4], 4'h0} : v.addr;
        for (int i = 0; i < int'(v.n); i++) begin
            chk(i == 0 ? "R3" : "R5", "start strobe", {31'b0, acc_start}, 32'd1);
            chk(i == 0 ? (v.size == 2'b11 ? "R12" : "R3") : "R5",
                "access address", acc_addr, ea);
            chk(kind_tag(v.kind), "size code", {30'b0, acc_size},
                {30'b0, v.codes[2*i +: 2]});
            if (intrude && i == 0) begin
                req_valid = 1'b1; req_addr = 32'hFFF0; req_size = 2'b01;
                chk("R2", "ready while busy", {31'b0, req_ready}, 32'd0);
                @(negedge clk);
                req_valid = 1'b0;
                chk("R2", "address after ignored request", acc_addr, ea);
            end
            for (int w = 0; w < int'(v.wt); w++) begin
                if (!(intrude && i == 0 && w == 0)) @(negedge clk);
                chk("R4", "strobe low while waiting", {31'b0, acc_start}, 32'd0);
                chk("R4", "address held", acc_addr, ea);
                chk("R4", "size held", {30'b0, acc_size}, {30'b0, v.codes[2*i +: 2]});
            end
            acc_ack = 1'b1;
            @(negedge clk);
            acc_ack = 1'b0;
            ea = ea + (32'd1 << v.lgs[2*i +: 2]);
        end
        chk("R11", "done after final ack", {31'b0, xfer_done}, 32'd1);
        chk("R11", "no strobe with done", {31'b0, acc_start}, 32'd0);
        @(negedge clk);
        chk("R11", "done is one cycle", {31'b0, xfer_done}, 32'd0);
        chk("R11", "ready after done", {31'b0, req_ready}, 32'd1);
        chk("R2", "no stray launch", {31'b0, acc_start}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2", "reset ready", {31'b0, req_ready}, 32'd1);
        chk("R3", "reset strobe", {31'b0, acc_start}, 32'd0);
        chk("R11", "reset done", {31'b0, xfer_done}, 32'd0);
        chk("R2", "reset active", {31'b0, acc_active}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

        // R2: request raised mid-transfer is ignored
        run_vec(VECS[2], 1'b1);

        // R11: acknowledge while idle has no effect
        @(negedge clk);
        acc_ack = 1'b1;
        @(negedge clk);
        acc_ack = 1'b0;
        chk("R11", "idle ack no done", {31'b0, xfer_done}, 32'd0);
        chk("R11", "idle ack no strobe", {31'b0, acc_start}, 32'd0);
        chk("R2", "idle ack still ready", {31'b0, req_ready}, 32'd1);

        // reset in the middle of a transfer returns to idle
        req_valid = 1'b1; req_addr = 32'h200; req_size = 2'b00;
        req_port = 2'b01; req_burst = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "launch before reset", {31'b0, acc_start}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2", "ready after mid reset", {31'b0, req_ready}, 32'd1);
        chk("R2", "inactive after mid reset", {31'b0, acc_active}, 32'd0);

        // back-to-back request right after reset
        run_vec(VECS[1], 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule